// File: doc/BRIEF.md
# Paged Address Translation Register File

This block sits between a 16-bit processor address bus and a 20-bit physical address bus. The top four address bits pick one of sixteen page entries. Each entry holds an 8-bit frame number, which replaces those four bits and widens the address to 1 MB. The low twelve bits pass through as the offset inside a 4 KB page. Each entry also keeps a permission flag that marks the page read-write or read-only. The flag drives an active-low write-protect output.

Each bus cycle has two phases, given by `phase_hi`. While the phase is low, the block translates the current address and captures the result in an output latch. While the phase is high, the latch holds that result, and the processor may read or write the table through a register window. The register index is the low four address bits. The permission flag of a write is not taken from the data bus. It comes from one spare address bit, so the table appears at two address aliases. After reset, translation is off and the address passes through unchanged. The first table write turns translation on. The table itself has no reset value, so software writes the entry for the page it is running from first, using an identity value.

Top module: `page_xlat`

## Requirements
- R1: Physical address bits 11:0 always equal CPU address bits 11:0 of the translated address.
- R2: With translation on, physical bits 19:12 equal the frame number stored in the entry indexed by CPU address bits 15:12.
- R3: With translation off, physical bits 15:12 equal CPU bits 15:12, physical bits 19:16 are zero, and `wp_n` is 1.
- R4: Reset turns translation off (`map_on` = 0). A table write turns it on, and it stays on until the next reset. Translated addresses apply from the next bus cycle.
- R5: The output latch captures on clock edges while `phase_hi` = 0. Changes of `cpu_addr` while `phase_hi` = 1 do not change `phys_addr` or `wp_n`.
- R6: A write takes place on a clock edge where `phase_hi`, `sel` and `wr` are all 1. It stores `wdata` in the entry indexed by `cpu_addr[3:0]`. A write attempt while `phase_hi` = 0, or while `sel` = 0, changes no entry.
- R7: A write with `cpu_addr[4]` = 1 marks the entry read-write, and a write with `cpu_addr[4]` = 0 marks it read-only. With translation on, `wp_n` is 0 exactly when the translated page is read-only.
- R8: While `phase_hi` = 1, `sel` = 1 and `wr` = 0, `rdata` equals the frame number of entry `cpu_addr[3:0]`. At all other times `rdata` is 0.
- R9: When `out_en` = 0, `phys_addr` is 0 and `phys_valid` is 0. When `out_en` = 1, `phys_valid` is 1.
- R10: After reset and before any write, the latched `phys_addr` is 0 and `wp_n` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Synchronous active-low reset |
| phase_hi | input | 1 | Bus phase: 0 = translate, 1 = CPU register access |
| cpu_addr | input | 16 | CPU address |
| sel | input | 1 | Register window select, active high |
| wr | input | 1 | 1 = write, 0 = read |
| wdata | input | 8 | Frame number to store |
| out_en | input | 1 | Enables the translated address output |
| rdata | output | 8 | Frame number read back |
| phys_addr | output | 20 | Latched physical address |
| phys_valid | output | 1 | High while `phys_addr` is presented |
| wp_n | output | 1 | Active-low write protect for the latched page |
| map_on | output | 1 | Translation enabled |

## Verification
The bench builds the block with its default parameters: 16 address bits, 4 index bits, 8 frame bits, and the alias on address bit 4. At these values every one of the sixteen entries, the full 256-frame range and both aliases can be reached in a short run. Random writes and translations are mixed with directed cases: the identity write that turns translation on, address changes during the high phase, write attempts in the wrong phase or without select, and a second reset. Expected values are checked only for entries written since power-up, so the uninitialised table contents never decide a result.

// File: rtl/page_xlat_pkg.sv
// Package: default geometry shared by the translation block and its bench.
// Assumes the frame width is at least the page index width.
package page_xlat_pkg;
    localparam int unsigned XL_VA_W     = 16;
    localparam int unsigned XL_PAGE_W   = 4;
    localparam int unsigned XL_FRAME_W  = 8;
    localparam int unsigned XL_ALIAS_BIT = 4;
endpackage

// File: rtl/page_xlat_table.sv
// Module: page entry storage. There is one write port and two
// asynchronous read ports: one for translation and one for the CPU
// register window. Contents are not reset, and software must write
// an entry before it relies on it.
module page_xlat_table #(
    parameter int unsigned PAGE_W  = 4,
    parameter int unsigned FRAME_W = 8
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               wr_en,
    input  logic [PAGE_W-1:0]  wr_idx,
    input  logic [FRAME_W-1:0] wr_frame,
    input  logic               wr_perm,
    input  logic [PAGE_W-1:0]  xl_idx,
    output logic [FRAME_W-1:0] xl_frame,
    output logic               xl_perm,
    input  logic [PAGE_W-1:0]  rd_idx,
    output logic [FRAME_W-1:0] rd_frame
);
    localparam int unsigned ENTRIES = 1 << PAGE_W;

    logic [FRAME_W-1:0] mem_frame [ENTRIES];
    logic               mem_perm  [ENTRIES];

    // Store frame and permission on a CPU write strobe.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_frame[wr_idx] <= wr_frame;
            mem_perm[wr_idx]  <= wr_perm;
        end
    end

    // Translation read port.
    always_comb begin
        xl_frame = mem_frame[xl_idx];
        xl_perm  = mem_perm[xl_idx];
    end

    // CPU register-window read port.
    always_comb rd_frame = mem_frame[rd_idx];

    p_store_frame_r6: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_frame[$past(wr_idx)] == $past(wr_frame)));

    p_store_perm_r7: assert property (@(posedge clk) disable iff (!rst_n)
        wr_en |=> (mem_perm[$past(wr_idx)] == $past(wr_perm)));
endmodule

// File: rtl/page_xlat_mode.sv
// Module: translation enable flag. It clears on reset and sets on the
// first table write. It never clears on its own.
module page_xlat_mode (
    input  logic clk,
    input  logic rst_n,
    input  logic wr_stb,
    output logic map_en
);
    // Sticky enable: set by any table write, cleared only by reset.
    always_ff @(posedge clk) begin
        if (!rst_n)      map_en <= 1'b0;
        else if (wr_stb) map_en <= 1'b1;
    end

    p_enable_on_write_r4: assert property (@(posedge clk) disable iff (!rst_n)
        wr_stb |=> map_en);

    p_enable_sticky_r4: assert property (@(posedge clk) disable iff (!rst_n)
        map_en |=> map_en);
endmodule

// File: rtl/page_xlat_latch.sv
// Module: output latch. During the low phase it forms the physical
// address, from the mapped frame or by passthrough when disabled,
// together with the write-permission flag. It holds both through the
// high phase.
module page_xlat_latch #(
    parameter int unsigned VA_W    = 16,
    parameter int unsigned PAGE_W  = 4,
    parameter int unsigned FRAME_W = 8
) (
    input  logic                            clk,
    input  logic                            rst_n,
    input  logic                            phase_hi,
    input  logic                            map_en,
    input  logic [VA_W-1:0]                 cpu_addr,
    input  logic [FRAME_W-1:0]              frame,
    input  logic                            perm,
    output logic [VA_W-PAGE_W+FRAME_W-1:0]  phys_q,
    output logic                            wr_ok_q
);
    localparam int unsigned OFF_W = VA_W - PAGE_W;
    localparam int unsigned PA_W  = OFF_W + FRAME_W;
    localparam int unsigned HI_W  = FRAME_W - PAGE_W;

    logic [PA_W-1:0] phys_d;
    logic            wr_ok_d;

    // Next physical address: mapped frame, or zero-extended page when off.
    always_comb begin
        if (map_en) phys_d = {frame, cpu_addr[OFF_W-1:0]};
        else        phys_d = {{HI_W{1'b0}}, cpu_addr};
        wr_ok_d = ~map_en | perm;
    end

    // Capture during the low phase, hold during the high phase.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phys_q  <= '0;
            wr_ok_q <= 1'b1;
        end else if (!phase_hi) begin
            phys_q  <= phys_d;
            wr_ok_q <= wr_ok_d;
        end
    end

    p_hold_high_r5: assert property (@(posedge clk) disable iff (!rst_n)
        phase_hi |=> ($stable(phys_q) && $stable(wr_ok_q)));

    p_passthrough_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (!phase_hi && !map_en) |=> (phys_q[PA_W-1 -: HI_W] == '0) && wr_ok_q);

    p_offset_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_hi |=> (phys_q[OFF_W-1:0] == $past(cpu_addr[OFF_W-1:0])));
endmodule

// File: rtl/page_xlat.sv
// Module: top of the paged address translator. It decodes the CPU
// register window, where the low address bits give the entry and one
// alias bit gives the permission, and ties together the table, the
// enable flag and the output latch. Assumes phase_hi is synchronous
// to clk.
module page_xlat
    import page_xlat_pkg::*;
#(
    parameter int unsigned VA_W      = XL_VA_W,
    parameter int unsigned PAGE_W    = XL_PAGE_W,
    parameter int unsigned FRAME_W   = XL_FRAME_W,
    parameter int unsigned ALIAS_BIT = XL_ALIAS_BIT
) (
    input  logic                           clk,
    input  logic                           rst_n,
    input  logic                           phase_hi,
    input  logic [VA_W-1:0]                cpu_addr,
    input  logic                           sel,
    input  logic                           wr,
    input  logic [FRAME_W-1:0]             wdata,
    input  logic                           out_en,
    output logic [FRAME_W-1:0]             rdata,
    output logic [VA_W-PAGE_W+FRAME_W-1:0] phys_addr,
    output logic                           phys_valid,
    output logic                           wp_n,
    output logic                           map_on
);
    localparam int unsigned OFF_W = VA_W - PAGE_W;
    localparam int unsigned PA_W  = OFF_W + FRAME_W;

    logic               wr_stb;
    logic               rd_stb;
    logic               map_en;
    logic [FRAME_W-1:0] xl_frame;
    logic               xl_perm;
    logic [FRAME_W-1:0] rd_frame;
    logic [PA_W-1:0]    phys_q;
    logic               wr_ok_q;

    // Register window decode for the high phase.
    always_comb begin
        wr_stb = phase_hi & sel & wr;
        rd_stb = phase_hi & sel & ~wr;
    end

    page_xlat_table #(.PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_table (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (wr_stb),
        .wr_idx   (cpu_addr[PAGE_W-1:0]),
        .wr_frame (wdata),
        .wr_perm  (cpu_addr[ALIAS_BIT]),
        .xl_idx   (cpu_addr[VA_W-1:OFF_W]),
        .xl_frame (xl_frame),
        .xl_perm  (xl_perm),
        .rd_idx   (cpu_addr[PAGE_W-1:0]),
        .rd_frame (rd_frame)
    );

    page_xlat_mode u_mode (
        .clk    (clk),
        .rst_n  (rst_n),
        .wr_stb (wr_stb),
        .map_en (map_en)
    );

    page_xlat_latch #(.VA_W(VA_W), .PAGE_W(PAGE_W), .FRAME_W(FRAME_W)) u_latch (
        .clk      (clk),
        .rst_n    (rst_n),
        .phase_hi (phase_hi),
        .map_en   (map_en),
        .cpu_addr (cpu_addr),
        .frame    (xl_frame),
        .perm     (xl_perm),
        .phys_q   (phys_q),
        .wr_ok_q  (wr_ok_q)
    );

    // Output drive: read data, gated address, protect flag, enable.
    always_comb begin
        rdata      = rd_stb ? rd_frame : '0;
        phys_addr  = out_en ? phys_q : '0;
        phys_valid = out_en;
        wp_n       = wr_ok_q;
        map_on     = map_en;
    end

    p_read_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !phase_hi |-> (rdata == '0));

    p_gate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        !phys_valid |-> (phys_addr == '0));
endmodule

// File: tb/page_xlat_tb.sv
module page_xlat_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        phase_hi = 1'b0;
    logic [15:0] cpu_addr = '0;
    logic        sel = 1'b0;
    logic        wr = 1'b0;
    logic [7:0]  wdata = '0;
    logic        out_en = 1'b1;
    logic [7:0]  rdata;
    logic [19:0] phys_addr;
    logic        phys_valid;
    logic        wp_n;
    logic        map_on;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    logic [7:0] m_frame [16];
    bit         m_perm  [16];
    bit         m_wrote [16];
    bit         m_on = 1'b0;

    always #2 clk = ~clk;

    page_xlat u_dut (
        .clk(clk), .rst_n(rst_n), .phase_hi(phase_hi), .cpu_addr(cpu_addr),
        .sel(sel), .wr(wr), .wdata(wdata), .out_en(out_en), .rdata(rdata),
        .phys_addr(phys_addr), .phys_valid(phys_valid), .wp_n(wp_n), .map_on(map_on)
    );

    function automatic logic [19:0] exp_phys(input logic [15:0] a);
        if (m_on) return {m_frame[a[15:12]], a[11:0]};
        return {4'h0, a};
    endfunction

    function automatic logic exp_wp(input logic [15:0] a);
        return !m_on || m_perm[a[15:12]];
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    // Translate one address over a full bus cycle, then check the result in the high phase.
    task automatic xlat(input logic [15:0] a, input string req);
        @(negedge clk); phase_hi = 1'b0; sel = 1'b0; wr = 1'b0; cpu_addr = a;
        @(negedge clk);
        @(negedge clk); phase_hi = 1'b1;
        @(negedge clk);
        check(req, {12'h0, phys_addr}, {12'h0, exp_phys(a)});
        check({req, " wp_n"}, {31'h0, wp_n}, {31'h0, exp_wp(a)});
    endtask

    // Register write in the high phase through the chosen alias.
    task automatic reg_write(input logic [3:0] idx, input bit rw, input logic [7:0] d);
        @(negedge clk); phase_hi = 1'b0; sel = 1'b0; wr = 1'b0;
        @(negedge clk); phase_hi = 1'b1; sel = 1'b1; wr = 1'b1;
        cpu_addr = {11'h400, rw, idx}; wdata = d;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
        m_frame[idx] = d; m_perm[idx] = rw; m_wrote[idx] = 1'b1; m_on = 1'b1;
    endtask

    task automatic reg_read(input logic [3:0] idx, input string req);
        @(negedge clk); phase_hi = 1'b1; sel = 1'b1; wr = 1'b0; cpu_addr = {12'h7F0, idx};
        #1 check(req, {24'h0, rdata}, {24'h0, m_frame[idx]});
        @(negedge clk); sel = 1'b0;
    endtask

    initial begin
        #(4 * 200000);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        logic [7:0] keep;
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R10 / R4: reset state
        check("R10 phys", {12'h0, phys_addr}, 32'h0);
        check("R10 wp_n", {31'h0, wp_n}, 32'h1);
        check("R4 map_on after reset", {31'h0, map_on}, 32'h0);
        check("R8 idle rdata", {24'h0, rdata}, 32'h0);

        // R3 / R1: passthrough while disabled
        xlat(16'hF123, "R3 passthrough");
        xlat(16'h3ABC, "R1 R3 passthrough");

        // R6: write with sel low is ignored, translation stays off
        @(negedge clk); phase_hi = 1'b1; sel = 1'b0; wr = 1'b1; cpu_addr = 16'h4015; wdata = 8'h55;
        @(negedge clk); wr = 1'b0;
        check("R6 no write without sel", {31'h0, map_on}, 32'h0);

        // R4: identity write for the running page enables translation
        reg_write(4'hF, 1'b1, 8'h0F);
        check("R4 map_on after write", {31'h0, map_on}, 32'h1);
        xlat(16'hF123, "R4 R2 identity page");

        // R2 / R7: fill all entries, alternating aliases
        for (int i = 0; i < 15; i++) reg_write(i[3:0], i[0], 8'($urandom));
        for (int i = 0; i < 16; i++) reg_read(i[3:0], "R8 readback");
        for (int i = 0; i < 16; i++) xlat({i[3:0], 12'($urandom)}, "R2 R7 mapped");

        // R6: low-phase write attempt must not change the entry
        keep = m_frame[3];
        @(negedge clk); phase_hi = 1'b0; sel = 1'b1; wr = 1'b1; cpu_addr = 16'h4013; wdata = ~keep;
        @(negedge clk); sel = 1'b0; wr = 1'b0;
        reg_read(4'h3, "R6 low-phase write ignored");

        // R8: read strobe in low phase returns zero
        @(negedge clk); phase_hi = 1'b0; sel = 1'b1; wr = 1'b0; cpu_addr = 16'h0005;
        #1 check("R8 low-phase read", {24'h0, rdata}, 32'h0);
        @(negedge clk); sel = 1'b0;

        // R5: address changes during the high phase do not disturb the latch
        xlat(16'h2468, "R5 setup");
        cpu_addr = 16'h9ACE;
        @(negedge clk);
        check("R5 hold", {12'h0, phys_addr}, {12'h0, exp_phys(16'h2468)});
        check("R5 hold wp_n", {31'h0, wp_n}, {31'h0, exp_wp(16'h2468)});

        // R7: same entry rewritten through each alias
        reg_write(4'h6, 1'b0, 8'hA6);
        xlat(16'h6000, "R7 read-only alias");
        reg_write(4'h6, 1'b1, 8'hB6);
        xlat(16'h6FFF, "R7 read-write alias");

        // R9: output gating
        out_en = 1'b0;
        @(negedge clk);
        check("R9 phys gated", {12'h0, phys_addr}, 32'h0);
        check("R9 valid low", {31'h0, phys_valid}, 32'h0);
        out_en = 1'b1;
        @(negedge clk);
        check("R9 valid high", {31'h0, phys_valid}, 32'h1);

        // Random mix of writes, reads and translations
        for (int k = 0; k < 300; k++) begin
            int op = int'($urandom % 4);
            logic [3:0] ix = 4'($urandom);
            if (op == 0)      reg_write(ix, 1'($urandom), 8'($urandom));
            else if (op == 1) reg_read(ix, "R8 random read");
            else              xlat({ix, 12'($urandom)}, "R2 R1 random xlat");
        end

        // R4: a second reset disables translation again
        @(negedge clk); rst_n = 1'b0;
        @(negedge clk); rst_n = 1'b1; m_on = 1'b0;
        check("R4 map_on after second reset", {31'h0, map_on}, 32'h0);
        xlat(16'hC321, "R3 passthrough after reset");

        done = 1'b1;
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule